// File: doc/BRIEF.md
# Dual-Channel Reset Command Sequencer

This block holds the shared master control register of a two-channel serial controller. Either channel's access path can write that register. Its two top bits carry a reset command. The command can leave both channels running, clear channel A, clear channel B, or perform a full reset that works like a hardware reset. A cleared channel has its receiver and transmitter turned off, its transmit line parked at mark, its modem control outputs driven high (inactive), and its interrupt enables, pending flags and in-service flags all zero.

A reset command does not take effect in a single cycle from the point of view of software. Each cleared channel raises a busy output for a fixed lockout window. While a channel's busy output is high, any write arriving through that channel's path is discarded. Each discarded write is counted in a saturating rejected-write counter.

The block also holds a small per-channel configuration, a per-channel interrupt enable mask and a global shift-direction bit, so that the effect of every reset can be observed at the ports. Interrupt sources set pending flags. A service strobe moves pending flags into the in-service set.

Top module: `chan_reset_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, every channel register, the interrupt flags, `mctl`, `shift_left`, `rej_count` and both busy outputs clear to zero. `txd_*`, `rts_n_*` and `dtr_n_*` are then high.
- R2: A master control write (`wr_addr`=2) with command bits [7:6]=00 loads `mctl` from data bits [5:0]. It leaves both channels unchanged and raises no busy output.
- R3: Command 01 clears channel B on the write's edge: rx/tx enables, interrupt enables, pending and in-service flags go to 0, `txd_b`=1, `rts_n_b`=`dtr_n_b`=1. Channel A keeps its state.
- R4: Command 10 clears channel A in the same way as R3, and channel B keeps its state.
- R5: Command 11 clears both channels. `mctl` bits 4, 3 and 2 take the written values, and bits 5, 1 and 0 clear. `shift_left` is unchanged.
- R6: Commands 01 and 10 also load `mctl` from data bits [5:0].
- R7: A cleared channel's busy output is high for exactly LOCK_CYC (default 4) consecutive cycles, starting the cycle after the command. A channel that is not cleared does not go busy, and writes through its path are still accepted during that time.
- R8: A write through a path whose channel is busy has no effect on any register. Each such write adds 1 to `rej_count`, which saturates at its maximum (255 by default).
- R9: The master control register is written identically through either path (`wr_path_b`=0 for A, 1 for B).
- R10: `wr_addr`=0 loads the path's channel config: bit0 receiver enable, bit1 transmitter enable, bit2 RTS, bit3 DTR. `wr_addr`=1 loads the interrupt enable mask from bits [3:0]. `wr_addr`=3 loads `shift_left` from bit0. An event sets a pending flag only when its enable bit is set. A service strobe moves its pending bits to in-service.
- R11: `txd_*` follows `txd_src_*` while the transmitter is enabled and is 1 otherwise. `rts_n_*` and `dtr_n_*` are the inverse of the stored RTS/DTR bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| wr_en | input | 1 | Register write strobe |
| wr_path_b | input | 1 | Access path of the write: 0 channel A, 1 channel B |
| wr_addr | input | 2 | Register select: 0 config, 1 interrupt enable, 2 master control, 3 shift direction |
| wr_data | input | 8 | Write data |
| evt_a | input | 4 | Channel A interrupt source events |
| evt_b | input | 4 | Channel B interrupt source events |
| svc_a | input | 4 | Channel A service strobes (pending to in-service) |
| svc_b | input | 4 | Channel B service strobes |
| txd_src_a | input | 1 | Channel A transmit data from the serializer |
| txd_src_b | input | 1 | Channel B transmit data from the serializer |
| rx_en_a | output | 1 | Channel A receiver enable |
| rx_en_b | output | 1 | Channel B receiver enable |
| tx_en_a | output | 1 | Channel A transmitter enable |
| tx_en_b | output | 1 | Channel B transmitter enable |
| txd_a | output | 1 | Channel A transmit line |
| txd_b | output | 1 | Channel B transmit line |
| rts_n_a | output | 1 | Channel A RTS, active low |
| rts_n_b | output | 1 | Channel B RTS, active low |
| dtr_n_a | output | 1 | Channel A DTR, active low |
| dtr_n_b | output | 1 | Channel B DTR, active low |
| ie_a | output | 4 | Channel A interrupt enables |
| ie_b | output | 4 | Channel B interrupt enables |
| ip_a | output | 4 | Channel A pending flags |
| ip_b | output | 4 | Channel B pending flags |
| ius_a | output | 4 | Channel A in-service flags |
| ius_b | output | 4 | Channel B in-service flags |
| busy_a | output | 1 | Channel A lockout active |
| busy_b | output | 1 | Channel B lockout active |
| mctl | output | 6 | Master control bits [5:0] |
| shift_left | output | 1 | Shift-direction bit |
| rej_count | output | 8 | Saturating count of dropped writes |

## Verification
Every register effect of a write, including channel clears, `mctl`, `shift_left` and the rejected-write count, is due on the clock edge that samples the write. The bench drives each write at a falling edge and removes it at the next falling edge, so it reads the result at that second falling edge. Busy is first visible at that same falling edge. The bench counts falling-edge samples while busy is high and expects exactly LOCK_CYC of them. To exercise dropping, writes are placed back to back on the edges inside that window. Transmit line and modem outputs are combinational from the stored bits, so they are checked at the same sample points.

// File: rtl/crs_pkg.sv
// Package: shared command codes, register selects and channel indices for
// the dual-channel reset command sequencer.
package crs_pkg;
    typedef enum logic [1:0] {
        CMD_NONE    = 2'b00,
        CMD_RST_B   = 2'b01,
        CMD_RST_A   = 2'b10,
        CMD_RST_ALL = 2'b11
    } rst_cmd_e;

    localparam int NUM_CH = 2;
    localparam int CH_A   = 0;
    localparam int CH_B   = 1;

    localparam logic [1:0] ADDR_CHCFG = 2'd0;
    localparam logic [1:0] ADDR_CHIE  = 2'd1;
    localparam logic [1:0] ADDR_MCTL  = 2'd2;
    localparam logic [1:0] ADDR_SHIFT = 2'd3;

    localparam int MCTL_W = 6;
    // master control bits that a full reset loads from the write data
    localparam int MB_DLC = 2;
    localparam int MB_MIE = 3;
    localparam int MB_SHI = 4;
endpackage

// File: rtl/crs_decode.sv
// Module: crs_decode
// Purpose: combinational decode of one register write into per-channel and
//          global actions, after gating by the busy state of the write path.
// Assumes: at most one write per cycle; busy[i] comes from the lockout timers.
module crs_decode
    import crs_pkg::*;
(
    input  logic              wr_en,
    input  logic              wr_path_b,
    input  logic [1:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [NUM_CH-1:0] busy,
    output logic              wr_drop,
    output logic              mctl_wr,
    output logic              full_rst,
    output logic              shift_wr,
    output logic [NUM_CH-1:0] ch_clr,
    output logic [NUM_CH-1:0] cfg_wr,
    output logic [NUM_CH-1:0] ie_wr
);
    logic     wr_ok;
    rst_cmd_e cmd;

    assign wr_drop = wr_en && busy[wr_path_b];
    assign wr_ok   = wr_en && !busy[wr_path_b];
    assign cmd     = rst_cmd_e'(wr_data[7:6]);

    // Purpose: turn an accepted write into strobes for the targeted state.
    always_comb begin
        mctl_wr  = 1'b0;
        full_rst = 1'b0;
        shift_wr = 1'b0;
        ch_clr   = '0;
        cfg_wr   = '0;
        ie_wr    = '0;
        if (wr_ok) begin
            case (wr_addr)
                ADDR_CHCFG: cfg_wr[wr_path_b] = 1'b1;
                ADDR_CHIE:  ie_wr[wr_path_b]  = 1'b1;
                ADDR_SHIFT: shift_wr          = 1'b1;
                default: begin
                    mctl_wr = 1'b1;
                    case (cmd)
                        CMD_RST_B: ch_clr[CH_B] = 1'b1;
                        CMD_RST_A: ch_clr[CH_A] = 1'b1;
                        CMD_RST_ALL: begin
                            ch_clr   = '1;
                            full_rst = 1'b1;
                        end
                        default: ;
                    endcase
                end
            endcase
        end
    end
endmodule

// File: rtl/crs_lockout.sv
// Module: crs_lockout
// Purpose: per-channel lockout timer; busy stays high for LOCK_CYC cycles
//          after the cycle in which start is seen. A new start restarts it.
// Assumes: LOCK_CYC >= 1.
module crs_lockout #(
    parameter int LOCK_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(LOCK_CYC + 1);

    logic [CW-1:0] cnt;

    // Purpose: load the window length on start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (start)
            cnt <= CW'(LOCK_CYC);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy); // R7
    AST_BUSY_ONLY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start)); // R7
endmodule

// File: rtl/crs_chan.sv
// Module: crs_chan
// Purpose: state of one serial channel as seen by the reset sequencer:
//          enables, modem bits, interrupt enable/pending/in-service flags.
// Assumes: NSRC <= 8 (the enable mask comes from the low data bits);
//          clr has priority over every other update in the same cycle.
module crs_chan #(
    parameter int NSRC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            cfg_wr,
    input  logic            ie_wr,
    input  logic [7:0]      wdata,
    input  logic [NSRC-1:0] evt,
    input  logic [NSRC-1:0] svc,
    input  logic            txd_src,
    output logic            rx_en,
    output logic            tx_en,
    output logic            txd,
    output logic            rts_n,
    output logic            dtr_n,
    output logic [NSRC-1:0] ie,
    output logic [NSRC-1:0] ip,
    output logic [NSRC-1:0] ius
);
    logic rts_q, dtr_q;

    // Purpose: channel configuration register (enables and modem bits).
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            rx_en <= 1'b0;
            tx_en <= 1'b0;
            rts_q <= 1'b0;
            dtr_q <= 1'b0;
        end else if (cfg_wr) begin
            rx_en <= wdata[0];
            tx_en <= wdata[1];
            rts_q <= wdata[2];
            dtr_q <= wdata[3];
        end
    end

    // Purpose: interrupt enable mask.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            ie <= '0;
        else if (ie_wr)
            ie <= wdata[NSRC-1:0];
    end

    // Purpose: pending flags set by enabled events, moved to in-service on svc.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ip  <= '0;
            ius <= '0;
        end else begin
            ip  <= (ip | (evt & ie)) & ~(svc & ip);
            ius <= ius | (svc & ip);
        end
    end

    // Transmit line parks at mark and modem outputs go inactive when cleared.
    assign txd   = tx_en ? txd_src : 1'b1;
    assign rts_n = ~rts_q;
    assign dtr_n = ~dtr_q;

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!rx_en && !tx_en && ie == '0 && ip == '0 && ius == '0
                 && rts_n && dtr_n && txd)); // R3
    AST_IP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (ip & ~$past(ip) & ~$past(ie)) == '0); // R10
    AST_IUS_FROM_IP: assert property (@(posedge clk) disable iff (!rst_n)
        (ius & ~$past(ius) & ~$past(ip)) == '0); // R10
endmodule

// File: rtl/chan_reset_seq.sv
// Module: chan_reset_seq (top)
// Purpose: shared master control register with reset command decode,
//          per-channel clear, post-reset lockout and dropped-write counting.
// Assumes: synchronous active-low reset; one write per cycle from either
//          access path; NSRC <= 8.
module chan_reset_seq
    import crs_pkg::*;
#(
    parameter int NSRC     = 4,
    parameter int LOCK_CYC = 4,
    parameter int CNT_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_path_b,
    input  logic [1:0]       wr_addr,
    input  logic [7:0]       wr_data,
    input  logic [NSRC-1:0]  evt_a,
    input  logic [NSRC-1:0]  evt_b,
    input  logic [NSRC-1:0]  svc_a,
    input  logic [NSRC-1:0]  svc_b,
    input  logic             txd_src_a,
    input  logic             txd_src_b,
    output logic             rx_en_a,
    output logic             rx_en_b,
    output logic             tx_en_a,
    output logic             tx_en_b,
    output logic             txd_a,
    output logic             txd_b,
    output logic             rts_n_a,
    output logic             rts_n_b,
    output logic             dtr_n_a,
    output logic             dtr_n_b,
    output logic [NSRC-1:0]  ie_a,
    output logic [NSRC-1:0]  ie_b,
    output logic [NSRC-1:0]  ip_a,
    output logic [NSRC-1:0]  ip_b,
    output logic [NSRC-1:0]  ius_a,
    output logic [NSRC-1:0]  ius_b,
    output logic             busy_a,
    output logic             busy_b,
    output logic [MCTL_W-1:0] mctl,
    output logic             shift_left,
    output logic [CNT_W-1:0] rej_count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic              wr_drop, mctl_wr, full_rst, shift_wr;
    logic [NUM_CH-1:0] ch_clr, cfg_wr, ie_wr, busy;
    logic [MCTL_W-1:0] mctl_next;

    logic [NSRC-1:0] evt_v [NUM_CH];
    logic [NSRC-1:0] svc_v [NUM_CH];
    logic [NSRC-1:0] ie_v  [NUM_CH];
    logic [NSRC-1:0] ip_v  [NUM_CH];
    logic [NSRC-1:0] ius_v [NUM_CH];
    logic [NUM_CH-1:0] txsrc_v, rx_v, tx_v, txd_v, rts_v, dtr_v;

    assign evt_v[CH_A] = evt_a;
    assign evt_v[CH_B] = evt_b;
    assign svc_v[CH_A] = svc_a;
    assign svc_v[CH_B] = svc_b;
    assign txsrc_v     = {txd_src_b, txd_src_a};

    crs_decode u_dec (
        .wr_en     (wr_en),
        .wr_path_b (wr_path_b),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .busy      (busy),
        .wr_drop   (wr_drop),
        .mctl_wr   (mctl_wr),
        .full_rst  (full_rst),
        .shift_wr  (shift_wr),
        .ch_clr    (ch_clr),
        .cfg_wr    (cfg_wr),
        .ie_wr     (ie_wr)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        crs_lockout #(.LOCK_CYC(LOCK_CYC)) u_lock (
            .clk   (clk),
            .rst_n (rst_n),
            .start (ch_clr[c]),
            .busy  (busy[c])
        );

        crs_chan #(.NSRC(NSRC)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (ch_clr[c]),
            .cfg_wr  (cfg_wr[c]),
            .ie_wr   (ie_wr[c]),
            .wdata   (wr_data),
            .evt     (evt_v[c]),
            .svc     (svc_v[c]),
            .txd_src (txsrc_v[c]),
            .rx_en   (rx_v[c]),
            .tx_en   (tx_v[c]),
            .txd     (txd_v[c]),
            .rts_n   (rts_v[c]),
            .dtr_n   (dtr_v[c]),
            .ie      (ie_v[c]),
            .ip      (ip_v[c]),
            .ius     (ius_v[c])
        );
    end

    // Purpose: next master control value; a full reset keeps only three bits.
    always_comb begin
        if (full_rst) begin
            mctl_next         = '0;
            mctl_next[MB_DLC] = wr_data[MB_DLC];
            mctl_next[MB_MIE] = wr_data[MB_MIE];
            mctl_next[MB_SHI] = wr_data[MB_SHI];
        end else begin
            mctl_next = wr_data[MCTL_W-1:0];
        end
    end

    // Purpose: master control register, written through either path.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mctl <= '0;
        else if (mctl_wr)
            mctl <= mctl_next;
    end

    // Purpose: shift-direction bit; only hardware reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shift_left <= 1'b0;
        else if (shift_wr)
            shift_left <= wr_data[0];
    end

    // Purpose: saturating count of writes dropped during a lockout.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rej_count <= '0;
        else if (wr_drop && rej_count != CNT_MAX)
            rej_count <= rej_count + 1'b1;
    end

    assign rx_en_a = rx_v[CH_A];
    assign rx_en_b = rx_v[CH_B];
    assign tx_en_a = tx_v[CH_A];
    assign tx_en_b = tx_v[CH_B];
    assign txd_a   = txd_v[CH_A];
    assign txd_b   = txd_v[CH_B];
    assign rts_n_a = rts_v[CH_A];
    assign rts_n_b = rts_v[CH_B];
    assign dtr_n_a = dtr_v[CH_A];
    assign dtr_n_b = dtr_v[CH_B];
    assign ie_a    = ie_v[CH_A];
    assign ie_b    = ie_v[CH_B];
    assign ip_a    = ip_v[CH_A];
    assign ip_b    = ip_v[CH_B];
    assign ius_a   = ius_v[CH_A];
    assign ius_b   = ius_v[CH_B];
    assign busy_a  = busy[CH_A];
    assign busy_b  = busy[CH_B];

    AST_DROP_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_drop && rej_count != CNT_MAX) |=> rej_count == $past(rej_count) + 1'b1); // R8
    AST_DROP_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_drop |=> ($stable(mctl) && $stable(shift_left))); // R8
    AST_SHIFT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        full_rst |=> $stable(shift_left)); // R5
    AST_BUSY_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_a) |-> $past(mctl_wr)); // R7
endmodule

// File: tb/sim_chan_reset_seq.sv
// Directed bench: one task per scenario, each checking its own results.
// Inputs change on falling edges; outputs are sampled on falling edges.
module sim_chan_reset_seq;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en, wr_path_b;
    logic [1:0] wr_addr;
    logic [7:0] wr_data;
    logic [3:0] evt_a, evt_b, svc_a, svc_b;
    logic       txd_src_a, txd_src_b;
    logic       rx_en_a, rx_en_b, tx_en_a, tx_en_b, txd_a, txd_b;
    logic       rts_n_a, rts_n_b, dtr_n_a, dtr_n_b;
    logic [3:0] ie_a, ie_b, ip_a, ip_b, ius_a, ius_b;
    logic       busy_a, busy_b;
    logic [5:0] mctl;
    logic       shift_left;
    logic [7:0] rej_count;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    chan_reset_seq u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_path_b(wr_path_b),
        .wr_addr(wr_addr), .wr_data(wr_data), .evt_a(evt_a), .evt_b(evt_b),
        .svc_a(svc_a), .svc_b(svc_b), .txd_src_a(txd_src_a), .txd_src_b(txd_src_b),
        .rx_en_a(rx_en_a), .rx_en_b(rx_en_b), .tx_en_a(tx_en_a), .tx_en_b(tx_en_b),
        .txd_a(txd_a), .txd_b(txd_b), .rts_n_a(rts_n_a), .rts_n_b(rts_n_b),
        .dtr_n_a(dtr_n_a), .dtr_n_b(dtr_n_b), .ie_a(ie_a), .ie_b(ie_b),
        .ip_a(ip_a), .ip_b(ip_b), .ius_a(ius_a), .ius_b(ius_b),
        .busy_a(busy_a), .busy_b(busy_b), .mctl(mctl), .shift_left(shift_left),
        .rej_count(rej_count)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One write, presented for one rising edge; returns at the next falling edge.
    task automatic wr(input logic pb, input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_path_b = pb; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset_state;
        chk("R1", "rx_en_a", rx_en_a, 0);
        chk("R1", "ie_b", ie_b, 0);
        chk("R1", "mctl", mctl, 0);
        chk("R1", "shift_left", shift_left, 0);
        chk("R1", "rej_count", rej_count, 0);
        chk("R1", "busy", {busy_a, busy_b}, 0);
        chk("R1", "line/modem high", {txd_a, txd_b, rts_n_a, dtr_n_b}, 4'hF);
    endtask

    task automatic t_config;
        wr(1'b0, 2'd0, 8'h0F);
        wr(1'b1, 2'd0, 8'h0F);
        wr(1'b0, 2'd1, 8'h0F);
        wr(1'b1, 2'd1, 8'h03);
        chk("R10", "enables a/b", {rx_en_a, tx_en_a, rx_en_b, tx_en_b}, 4'hF);
        chk("R11", "modem active", {rts_n_a, dtr_n_a, rts_n_b, dtr_n_b}, 0);
        chk("R10", "ie_a", ie_a, 4'hF);
        chk("R10", "ie_b", ie_b, 4'h3);
        txd_src_a = 1'b0; txd_src_b = 1'b0;
        #1;
        chk("R11", "txd follows source", {txd_a, txd_b}, 0);
        evt_a = 4'b0101; evt_b = 4'b1101;
        @(negedge clk);
        evt_a = 0; evt_b = 0;
        chk("R10", "ip_a", ip_a, 4'b0101);
        chk("R10", "ip_b gated by ie", ip_b, 4'b0001);
        svc_a = 4'b0001; svc_b = 4'b0001;
        @(negedge clk);
        svc_a = 0; svc_b = 0;
        chk("R10", "ius_a", ius_a, 4'b0001);
        chk("R10", "ip_a after svc", ip_a, 4'b0100);
        chk("R10", "ius_b", ius_b, 4'b0001);
    endtask

    task automatic t_null;
        wr(1'b0, 2'd2, 8'h3F);
        chk("R2", "mctl", mctl, 6'h3F);
        chk("R2", "no busy", {busy_a, busy_b}, 0);
        chk("R2", "a untouched", {rx_en_a, ip_a}, {1'b1, 4'b0100});
        chk("R2", "b untouched", {tx_en_b, ius_b}, {1'b1, 4'b0001});
        wr(1'b1, 2'd2, 8'h15);
        chk("R9", "mctl via path b", mctl, 6'h15);
    endtask

    task automatic t_reset_b;
        int n;
        wr(1'b0, 2'd2, 8'h4A);
        chk("R3", "b enables off", {rx_en_b, tx_en_b}, 0);
        chk("R3", "b flags clear", {ie_b, ip_b, ius_b}, 0);
        chk("R3", "b line/modem", {txd_b, rts_n_b, dtr_n_b}, 3'b111);
        chk("R3", "a kept", {rx_en_a, ie_a, ius_a}, {1'b1, 4'hF, 4'b0001});
        chk("R6", "mctl", mctl, 6'h0A);
        n = 0;
        for (int i = 0; i < 20; i++) begin
            if (!busy_b) break;
            if (busy_a) chk("R7", "busy_a stays low", busy_a, 0);
            n++;
            @(negedge clk);
        end
        chk("R7", "busy_b length", n, 4);
    endtask

    task automatic t_drop;
        logic [7:0] r0;
        r0 = rej_count;
        wr(1'b0, 2'd2, 8'h40);
        wr(1'b0, 2'd1, 8'h09);
        chk("R7", "other path accepted", ie_a, 4'h9);
        wr(1'b1, 2'd0, 8'h0F);
        wr(1'b1, 2'd0, 8'h0F);
        wr(1'b1, 2'd0, 8'h0F);
        chk("R8", "dropped no effect", rx_en_b, 0);
        chk("R8", "rej_count", rej_count, r0 + 8'd3);
        wr(1'b1, 2'd0, 8'h0F);
        chk("R7", "accepted after window", rx_en_b, 1);
        chk("R8", "rej_count stable", rej_count, r0 + 8'd3);
    endtask

    task automatic t_reset_a;
        wr(1'b1, 2'd2, 8'h84);
        chk("R4", "a cleared", {rx_en_a, tx_en_a, ie_a, ius_a, ip_a}, 0);
        chk("R4", "a line/modem", {txd_a, rts_n_a, dtr_n_a}, 3'b111);
        chk("R4", "b kept", rx_en_b, 1);
        chk("R6", "mctl", mctl, 6'h04);
        chk("R7", "busy a only", {busy_a, busy_b}, 2'b10);
        repeat (5) @(negedge clk);
    endtask

    task automatic t_full;
        wr(1'b0, 2'd3, 8'h01);
        chk("R10", "shift_left set", shift_left, 1);
        wr(1'b0, 2'd0, 8'h0F);
        wr(1'b1, 2'd2, 8'h3F);
        wr(1'b0, 2'd2, 8'hFF);
        chk("R5", "mctl keeps 4:2", mctl, 6'h1C);
        chk("R5", "shift kept", shift_left, 1);
        chk("R5", "both cleared", {rx_en_a, rx_en_b, tx_en_a, tx_en_b}, 0);
        chk("R7", "both busy", {busy_a, busy_b}, 2'b11);
        repeat (5) @(negedge clk);
    endtask

    task automatic t_saturate;
        for (int i = 0; i < 70; i++) begin
            wr(1'b0, 2'd2, 8'h40);
            for (int j = 0; j < 4; j++) wr(1'b1, 2'd1, 8'h0F);
        end
        chk("R8", "saturated", rej_count, 8'hFF);
        chk("R8", "drops ignored", ie_b, 0);
    endtask

    task automatic t_hw_reset;
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R1", "shift cleared", shift_left, 0);
        chk("R1", "rej cleared", rej_count, 0);
        chk("R1", "mctl cleared", mctl, 0);
        rst_n = 1'b1;
    endtask

    initial begin
        rst_n = 1'b0; wr_en = 0; wr_path_b = 0; wr_addr = 0; wr_data = 0;
        evt_a = 0; evt_b = 0; svc_a = 0; svc_b = 0;
        txd_src_a = 1'b1; txd_src_b = 1'b1;
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        @(negedge clk);
        t_config();
        t_null();
        t_reset_b();
        t_drop();
        t_reset_a();
        t_full();
        t_saturate();
        t_hw_reset();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule